// File: doc/BRIEF.md
# Linked-List Descriptor Walker

A single DMA channel front end that walks chains of 24-byte transfer descriptors held in memory. Each data element is fetched one 32-bit word at a time through a simple read port. It is accepted only when its cycle bit agrees with the channel's consumer cycle state, and it is then handed to an external mover as one copy command carrying source, destination and byte count. Link elements redirect fetching to another list or back to the head of the same list. A link can also flip the consumer cycle state, so a ring of descriptors can be reused lap after lap.

Software programs the consumer cycle state, the list-enable flag and the 64-bit list pointer through a small valid/ready register port. It then rings a doorbell that names the channel. The channel runs until it meets an element whose cycle bit does not match, and then parks. The producer refills the ring and rings the doorbell again to resume from the parked element. An element that has either interrupt-enable bit set produces a one-cycle interrupt pulse once its copy completes.

Top module: `ll_dma_walker`

## Requirements
- R1: After reset the status field reads 0, the cycle state and list-enable read 0, both pointer halves read 0, and mem_req_o, cmd_valid_o and irq_o are low.
- R2: Register offsets are word indices on reg_addr_i. Offset 0 is control: bit 9 is list-enable, bit 8 is the consumer cycle state (reads the live value), and bits [1:0] are the read-only status. Offset 1 is the pointer low half and offset 2 is the high half; both read back the current fetch address. Offset 3 is the doorbell, with the channel number in bits [CH_BITS-1:0]. Read data appears with reg_rvalid_o one cycle after the read is accepted. reg_ready_o is always high.
- R3: A doorbell naming CH_ID, with list-enable set and the channel not running, sets status to 1 (running) and starts fetching at the pointer. A doorbell with another channel number, or one that arrives while list-enable is clear, changes nothing.
- R4: An element occupies six words at increasing addresses: control, size, source low, source high, destination low, destination high. In the control word, bit 0 is the cycle bit, bit 1 is toggle-cycle, bit 2 marks a link, bit 3 is the local interrupt enable and bit 4 is the remote interrupt enable.
- R5: An element is consumed only if its cycle bit equals the consumer cycle state. On a mismatch the status becomes 3, the pointer stays on that element and the cycle state is kept. The next accepted doorbell refetches that element.
- R6: A consumed data element produces exactly one cmd_valid_o pulse carrying its source, destination and size. The next fetch begins only after cmd_done_i, and the pointer then advances by 24.
- R7: A consumed link element loads the pointer from word 2 (low) and word 3 (high), and fetching continues there. If toggle-cycle is set the consumer cycle state inverts; otherwise it is unchanged.
- R8: irq_o pulses for one cycle, in the cycle after cmd_done_i, for a data element with bit 3 or bit 4 set. No pulse is produced for any other element.
- R9: Writes to the control or pointer registers while the status is 1 are ignored.
- R10: The memory port has at most one read outstanding. Each request is a one-cycle mem_req_o, and the data returns with mem_rvalid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access request |
| reg_ready_o | output | 1 | Register port ready (always 1) |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 64 | Byte address of requested word |
| mem_rvalid_i | input | 1 | Descriptor word returned |
| mem_rdata_i | input | 32 | Descriptor word data |
| cmd_valid_o | output | 1 | Copy command pulse |
| cmd_src_o | output | 64 | Copy source address |
| cmd_dst_o | output | 64 | Copy destination address |
| cmd_size_o | output | 32 | Copy byte count |
| cmd_done_i | input | 1 | Copy finished pulse |
| irq_o | output | 1 | Done-interrupt request pulse |

## Verification
The bench builds the block with CH_ID set to 2 and a 3-bit channel field. This makes a doorbell with a neighbouring channel number a meaningful negative case. It sweeps ring lengths of one to four data elements under both starting cycle polarities. Each run takes two laps: the first parks on the link element, and the second consumes the link, toggles the cycle state and reruns the ring with refreshed contents. The copy latency is varied between runs. Further cases cover a link without toggle into a list at a nonzero upper address, elements with only one interrupt enable, a mismatch on the first element, and register writes made while a slow copy is in progress.

// File: rtl/ll_walk_pkg.sv
package ll_walk_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 64;
  localparam int ELEM_WORDS = 6;
  localparam int ELEM_BYTES = ELEM_WORDS * (WORD_W / 8);
  localparam int IDX_W      = $clog2(ELEM_WORDS);

  // element control word fields
  localparam int CF_CYCLE  = 0;
  localparam int CF_TOGGLE = 1;
  localparam int CF_LINK   = 2;
  localparam int CF_LIE    = 3;
  localparam int CF_RIE    = 4;

  // channel control register fields
  localparam int CTL_CCS = 8;
  localparam int CTL_LLE = 9;

  localparam logic [1:0] RA_CTRL   = 2'd0;
  localparam logic [1:0] RA_PTR_LO = 2'd1;
  localparam logic [1:0] RA_PTR_HI = 2'd2;
  localparam logic [1:0] RA_BELL   = 2'd3;

  typedef enum logic [1:0] {
    CH_RESET = 2'd0,
    CH_RUN   = 2'd1,
    CH_STOP  = 2'd3
  } ch_status_e;

  typedef enum logic [2:0] {
    WS_IDLE, WS_REQ, WS_WAIT, WS_CMD, WS_DONE
  } walk_state_e;
endpackage

// File: rtl/ll_walk_regs.sv
module ll_walk_regs
  import ll_walk_pkg::*;
#(
  parameter int CH_ID   = 0,
  parameter int CH_BITS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic              reg_rvalid_o,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  ch_status_e        status_i,
  input  logic              ccs_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              start_o,
  output logic              ld_ccs_o,
  output logic              ccs_val_o,
  output logic              ld_lo_o,
  output logic              ld_hi_o,
  output logic [WORD_W-1:0] ld_data_o
);
  localparam logic [CH_BITS-1:0] MY_CH = CH_BITS'(CH_ID);

  logic              lle_q;
  logic              wr, rd, running;
  logic [WORD_W-1:0] rd_ctrl, rd_mux;

  assign running   = (status_i == CH_RUN);
  assign wr        = reg_valid_i & reg_write_i;
  assign rd        = reg_valid_i & ~reg_write_i;
  assign ld_ccs_o  = wr & (reg_addr_i == RA_CTRL) & ~running;
  assign ld_lo_o   = wr & (reg_addr_i == RA_PTR_LO) & ~running;
  assign ld_hi_o   = wr & (reg_addr_i == RA_PTR_HI) & ~running;
  assign ccs_val_o = reg_wdata_i[CTL_CCS];
  assign ld_data_o = reg_wdata_i;
  assign start_o   = wr & (reg_addr_i == RA_BELL) &
                     (reg_wdata_i[CH_BITS-1:0] == MY_CH) & lle_q & ~running;

  always_comb begin
    rd_ctrl          = '0;
    rd_ctrl[CTL_LLE] = lle_q;
    rd_ctrl[CTL_CCS] = ccs_i;
    rd_ctrl[1:0]     = status_i;
    case (reg_addr_i)
      RA_CTRL:   rd_mux = rd_ctrl;
      RA_PTR_LO: rd_mux = ptr_i[WORD_W-1:0];
      RA_PTR_HI: rd_mux = ptr_i[ADDR_W-1:WORD_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lle_q        <= 1'b0;
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= rd;
      if (rd) reg_rdata_o <= rd_mux;
      if (ld_ccs_o) lle_q <= reg_wdata_i[CTL_LLE];
    end
  end
endmodule

// File: rtl/ll_walk_fsm.sv
module ll_walk_fsm
  import ll_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ld_ccs_i,
  input  logic              ccs_val_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_src_o,
  output logic [ADDR_W-1:0] cmd_dst_o,
  output logic [WORD_W-1:0] cmd_size_o,
  input  logic              cmd_done_i,
  output logic              irq_o,
  output ch_status_e        status_o,
  output logic              ccs_o,
  output logic [ADDR_W-1:0] ptr_o
);
  walk_state_e       state_q;
  ch_status_e        status_q;
  logic              ccs_q, irq_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [WORD_W-1:0] word_q [ELEM_WORDS];
  logic              want_irq;

  assign want_irq    = word_q[0][CF_LIE] | word_q[0][CF_RIE];
  assign mem_req_o   = (state_q == WS_REQ);
  assign mem_addr_o  = ptr_q + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign cmd_valid_o = (state_q == WS_CMD);
  assign cmd_size_o  = word_q[1];
  assign cmd_src_o   = {word_q[3], word_q[2]};
  assign cmd_dst_o   = {word_q[5], word_q[4]};
  assign irq_o       = irq_q;
  assign status_o    = status_q;
  assign ccs_o       = ccs_q;
  assign ptr_o       = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WS_IDLE;
      status_q <= CH_RESET;
      ccs_q    <= 1'b0;
      irq_q    <= 1'b0;
      ptr_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      for (int i = 0; i < ELEM_WORDS; i++) word_q[i] <= '0;
    end else begin
      irq_q <= 1'b0;
      if (ld_ccs_i) ccs_q <= ccs_val_i;
      if (ld_lo_i)  ptr_q[WORD_W-1:0] <= ld_data_i;
      if (ld_hi_i)  ptr_q[ADDR_W-1:WORD_W] <= ld_data_i;
      case (state_q)
        WS_IDLE: if (start_i) begin
          status_q <= CH_RUN;
          idx_q    <= '0;
          state_q  <= WS_REQ;
        end
        WS_REQ: state_q <= WS_WAIT;
        WS_WAIT: if (mem_rvalid_i) begin
          word_q[idx_q] <= mem_rdata_i;
          if (idx_q == '0) begin
            if (mem_rdata_i[CF_CYCLE] != ccs_q) begin
              // producer has not handed this element over yet: park here
              status_q <= CH_STOP;
              state_q  <= WS_IDLE;
            end else if (mem_rdata_i[CF_LINK]) begin
              idx_q   <= IDX_W'(2);
              last_q  <= IDX_W'(3);
              state_q <= WS_REQ;
            end else begin
              idx_q   <= IDX_W'(1);
              last_q  <= IDX_W'(ELEM_WORDS-1);
              state_q <= WS_REQ;
            end
          end else if (idx_q != last_q) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= WS_REQ;
          end else if (word_q[0][CF_LINK]) begin
            ptr_q   <= {mem_rdata_i, word_q[2]};
            if (word_q[0][CF_TOGGLE]) ccs_q <= ~ccs_q;
            idx_q   <= '0;
            state_q <= WS_REQ;
          end else begin
            state_q <= WS_CMD;
          end
        end
        WS_CMD: state_q <= WS_DONE;
        WS_DONE: if (cmd_done_i) begin
          irq_q   <= want_irq;
          ptr_q   <= ptr_q + ADDR_W'(ELEM_BYTES);
          idx_q   <= '0;
          state_q <= WS_REQ;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker
  import ll_walk_pkg::*;
#(
  parameter int CH_ID   = 0,
  parameter int CH_BITS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_valid_i,
  output logic        reg_ready_o,
  input  logic        reg_write_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic        reg_rvalid_o,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [63:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        cmd_valid_o,
  output logic [63:0] cmd_src_o,
  output logic [63:0] cmd_dst_o,
  output logic [31:0] cmd_size_o,
  input  logic        cmd_done_i,
  output logic        irq_o
);
  ch_status_e        status_w;
  logic              ccs_w, start_w, ld_ccs_w, ccs_val_w, ld_lo_w, ld_hi_w;
  logic [ADDR_W-1:0] ptr_w;
  logic [WORD_W-1:0] ld_data_w;

  assign reg_ready_o = 1'b1;

  ll_walk_regs #(.CH_ID(CH_ID), .CH_BITS(CH_BITS)) u_regs (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .reg_rvalid_o, .reg_rdata_o,
    .status_i(status_w), .ccs_i(ccs_w), .ptr_i(ptr_w),
    .start_o(start_w), .ld_ccs_o(ld_ccs_w), .ccs_val_o(ccs_val_w),
    .ld_lo_o(ld_lo_w), .ld_hi_o(ld_hi_w), .ld_data_o(ld_data_w)
  );

  ll_walk_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start_w), .ld_ccs_i(ld_ccs_w), .ccs_val_i(ccs_val_w),
    .ld_lo_i(ld_lo_w), .ld_hi_i(ld_hi_w), .ld_data_i(ld_data_w),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .cmd_valid_o, .cmd_src_o, .cmd_dst_o, .cmd_size_o, .cmd_done_i,
    .irq_o, .status_o(status_w), .ccs_o(ccs_w), .ptr_o(ptr_w)
  );
endmodule

// File: rtl/ll_dma_walker_chk.sv
module ll_dma_walker_chk
  import ll_walk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_req_o,
  input logic       cmd_valid_o,
  input logic       cmd_done_i,
  input logic       irq_o,
  input ch_status_e status_w,
  input logic       ccs_w,
  input logic       ld_ccs_w,
  input logic       start_w
);
  a_r8_irq_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cmd_done_i));

  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r6_cmd_only_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> status_w == CH_RUN);

  a_r10_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r5_ccs_held_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w != CH_RUN && !ld_ccs_w) |=> $stable(ccs_w));

  a_r3_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> status_w == CH_RUN);

  a_r1_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w != ch_status_e'(2'd2));
endmodule

bind ll_dma_walker ll_dma_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o),
  .cmd_valid_o(cmd_valid_o), .cmd_done_i(cmd_done_i), .irq_o(irq_o),
  .status_w(status_w), .ccs_w(ccs_w), .ld_ccs_w(ld_ccs_w), .start_w(start_w)
);

// File: tb/sim_ll_dma_walker.sv
module sim_ll_dma_walker;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 2;
  localparam int B  = 'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 0, reg_write = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic reg_ready, reg_rvalid, mem_req, mem_rvalid = 0, cmd_valid, irq;
  logic cmd_done = 0;
  logic [31:0] reg_rdata, mem_rdata = 0, cmd_size;
  logic [63:0] mem_addr, cmd_src, cmd_dst;

  int n_chk = 0, n_err = 0;
  int done_lat = 1, dcnt = 0;
  int cmd_n = 0, irq_n = 0;
  logic [31:0] mem [0:255];
  logic [63:0] src_log [0:63];
  logic [63:0] dst_log [0:63];
  logic [31:0] size_log [0:63];
  int irq_tag [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  ll_dma_walker #(.CH_ID(CH), .CH_BITS(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(reg_valid), .reg_ready_o(reg_ready),
    .reg_write_i(reg_write), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rvalid_o(reg_rvalid), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .cmd_valid_o(cmd_valid), .cmd_src_o(cmd_src),
    .cmd_dst_o(cmd_dst), .cmd_size_o(cmd_size), .cmd_done_i(cmd_done), .irq_o(irq)
  );

  // memory and copy-engine models
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    if (mem_req) mem_rdata <= mem[mem_addr[9:2]];
    cmd_done <= 1'b0;
    if (cmd_valid) begin
      src_log[cmd_n & 63]  <= cmd_src;
      dst_log[cmd_n & 63]  <= cmd_dst;
      size_log[cmd_n & 63] <= cmd_size;
      cmd_n <= cmd_n + 1;
      dcnt  <= done_lat;
    end else if (dcnt > 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) cmd_done <= 1'b1;
    end
    if (irq) begin
      irq_tag[irq_n & 63] <= cmd_n;
      irq_n <= irq_n + 1;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    d = reg_rvalid ? reg_rdata : 32'hxxxx_xxxx;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(0, v);
      if (v[1:0] != 2'd1) break;
    end
  endtask

  function automatic logic [63:0] exp_src(int lap, int k);
    return {32'h00A0_0000 + 32'(lap * 16 + k), 32'h1000_0000 + 32'(k * 'h100 + lap)};
  endfunction
  function automatic logic [63:0] exp_dst(int lap, int k);
    return {32'h00B0_0000 + 32'(lap * 16 + k), 32'h2000_0000 + 32'(k * 'h200 + lap)};
  endfunction
  function automatic logic [31:0] exp_size(int lap, int k);
    return 32'(64 * (k + 1) + lap);
  endfunction

  task automatic put_data(int a, logic [31:0] ctl, int lap, int k);
    mem[(a >> 2) + 0] = ctl;
    mem[(a >> 2) + 1] = exp_size(lap, k);
    mem[(a >> 2) + 2] = exp_src(lap, k)[31:0];
    mem[(a >> 2) + 3] = exp_src(lap, k)[63:32];
    mem[(a >> 2) + 4] = exp_dst(lap, k)[31:0];
    mem[(a >> 2) + 5] = exp_dst(lap, k)[63:32];
  endtask

  task automatic put_link(int a, logic [31:0] ctl, logic [63:0] p);
    mem[(a >> 2) + 0] = ctl;
    mem[(a >> 2) + 1] = 32'h0;
    mem[(a >> 2) + 2] = p[31:0];
    mem[(a >> 2) + 3] = p[63:32];
  endtask

  // ring of n data elements (last with both enables), link back to head
  task automatic build_ring(int n, logic cyc, int lap);
    for (int k = 0; k < n; k++)
      put_data(B + 24 * k, {27'd0, (k == n - 1) ? 2'b11 : 2'b00, 2'b00, cyc}, lap, k);
    put_link(B + 24 * n, {29'd0, 3'b110} | {31'd0, ~cyc}, 64'(B));
  endtask

  task automatic run_lap(int n, int lap, logic exp_ccs);
    int c0, i0;
    logic [31:0] v;
    c0 = cmd_n; i0 = irq_n;
    reg_wr(3, 32'(CH));
    wait_stop();
    repeat (3) @(negedge clk);
    check("R6 command count", 64'(cmd_n - c0), 64'(n));
    for (int k = 0; k < n; k++) begin
      check("R6 src", src_log[(c0 + k) & 63], exp_src(lap, k));
      check("R6 dst", dst_log[(c0 + k) & 63], exp_dst(lap, k));
      check("R4 size", 64'(size_log[(c0 + k) & 63]), 64'(exp_size(lap, k)));
    end
    check("R8 irq count", 64'(irq_n - i0), 64'd1);
    check("R8 irq after last element", 64'(irq_tag[i0 & 63]), 64'(c0 + n));
    reg_rd(1, v); check("R5 parked ptr lo", 64'(v), 64'(B + 24 * n));
    reg_rd(2, v); check("R2 ptr hi", 64'(v), 64'd0);
    reg_rd(0, v);
    check("R5 status stopped", 64'(v[1:0]), 64'd3);
    check("R7 cycle state", 64'(v[8]), 64'(exp_ccs));
  endtask

  initial begin
    logic [31:0] v;
    int c0, i0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 cmd_valid", 64'(cmd_valid), 64'd0);
    check("R1 mem_req", 64'(mem_req), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    rst_n = 1'b1;
    check("R2 ready", 64'(reg_ready), 64'd1);
    reg_rd(0, v); check("R1 control", 64'(v), 64'd0);
    reg_rd(1, v); check("R1 ptr lo", 64'(v), 64'd0);
    reg_rd(2, v); check("R1 ptr hi", 64'(v), 64'd0);

    // sweep: polarity x ring length, two laps each
    for (int c = 0; c < 2; c++) begin
      for (int n = 1; n <= 4; n++) begin
        done_lat = 1 + (n % 3);
        build_ring(n, c[0], 0);
        reg_wr(0, (32'(c) << 8) | 32'h200);
        reg_wr(1, 32'(B));
        reg_wr(2, 32'h0);
        reg_rd(0, v);
        check("R2 control readback", 64'(v[9:8]), 64'({1'b1, c[0]}));
        run_lap(n, 0, c[0]);
        build_ring(n, ~c[0], 1);
        run_lap(n, 1, ~c[0]);
      end
    end

    // R7 link without toggle into a list at a nonzero upper address
    put_data('h300, 32'h9, 2, 0);        // local enable only, cycle 1
    put_link('h318, 32'h5, {32'h5, 32'h200});
    put_data('h200, 32'h11, 3, 0);       // remote enable only, cycle 1
    mem[('h218) >> 2] = 32'h0;           // cycle 0: park
    reg_wr(0, 32'h300);
    reg_wr(1, 32'h300);
    reg_wr(2, 32'h0);
    c0 = cmd_n; i0 = irq_n;
    reg_wr(3, 32'(CH));
    wait_stop();
    repeat (3) @(negedge clk);
    check("R7 commands through plain link", 64'(cmd_n - c0), 64'd2);
    check("R7 second list src", src_log[(c0 + 1) & 63], exp_src(3, 0));
    check("R8 single-enable irqs", 64'(irq_n - i0), 64'd2);
    reg_rd(2, v); check("R7 linked ptr hi", 64'(v), 64'h5);
    reg_rd(1, v); check("R7 linked ptr lo", 64'(v), 64'h218);
    reg_rd(0, v); check("R7 no toggle keeps cycle", 64'(v[8]), 64'd1);

    // R3 doorbells that must be ignored
    c0 = cmd_n;
    mem[('h218) >> 2] = 32'h1;           // would now be consumable
    reg_wr(3, 32'(CH + 1));
    repeat (10) @(negedge clk);
    reg_rd(0, v); check("R3 other channel ignored", 64'(v[1:0]), 64'd3);
    reg_wr(0, 32'h100);                  // list-enable clear
    reg_wr(3, 32'(CH));
    repeat (10) @(negedge clk);
    reg_rd(0, v); check("R3 disabled list ignored", 64'(v[1:0]), 64'd3);
    check("R3 no commands", 64'(cmd_n - c0), 64'd0);

    // R5 mismatch on very first element
    put_data('h380, 32'h0, 4, 0);
    reg_wr(0, 32'h300);
    reg_wr(1, 32'h380);
    reg_wr(2, 32'h0);
    reg_wr(3, 32'(CH));
    wait_stop();
    reg_rd(1, v); check("R5 parked on first", 64'(v), 64'h380);
    check("R5 nothing issued", 64'(cmd_n - c0), 64'd0);

    // R9 writes during a slow copy
    done_lat = 60;
    mem[('h380) >> 2] = 32'h1;
    mem[('h398) >> 2] = 32'h0;
    reg_wr(3, 32'(CH));
    repeat (15) @(negedge clk);
    reg_rd(0, v); check("R3 running status", 64'(v[1:0]), 64'd1);
    reg_rd(1, v); check("R6 ptr held during copy", 64'(v), 64'h380);
    reg_wr(1, 32'h0);
    reg_wr(2, 32'hFFFF);
    reg_wr(0, 32'h0);
    wait_stop();
    reg_rd(1, v); check("R9 ptr lo write ignored", 64'(v), 64'h398);
    reg_rd(2, v); check("R9 ptr hi write ignored", 64'(v), 64'h0);
    reg_rd(0, v); check("R9 control write ignored", 64'(v[9:8]), 64'h3);
    check("R6 one command", 64'(cmd_n - c0), 64'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule